// File: doc/BRIEF.md
# Parallel Byte Handshake Sender with Block Gating

This block is the host side of an 8-bit parallel byte link to a peripheral that consumes data in fixed-size blocks. Bytes arrive on a valid/ready stream. Each accepted byte is placed on the parallel bus. After a programmable setup interval the block raises a request strobe. It then waits for the peripheral to pull its active-low ready-to-receive line, and it keeps the byte on the bus through a programmable hold interval after the strobe drops.

The peripheral controls block boundaries through an end-of-block window line. New bytes are taken only while that line is high. Once a full block of 15 acknowledged bytes has gone out, the sender stops. It waits for the window line to fall and then rise again before it takes the next byte. If the peripheral closes the window early, the sender stops at once and starts a fresh block count when the window reopens. If a request goes unanswered for a programmable number of cycles, the sender withdraws the request and raises a sticky error flag.

Setup, minimum pulse width, hold and timeout are run-time inputs counted in clock cycles. A programmed value of zero acts as one. Both peripheral inputs are asynchronous and pass through two-flop synchronizers before any decision uses them.

Top module: `pdma_tx`

## Requirements
- R1: While reset is held, and immediately after it, `pio_req_o`, `in_ready_o` and `tmo_err_o` are low. With `eob_i` high, `in_ready_o` first goes high on the third rising clock edge after reset release.
- R2: `in_ready_o` is high only while the sender is idle and the synchronized window line is high. A byte is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high, and it appears on `pio_data_o` at that edge.
- R3: `pio_req_o` rises exactly max(`setup_cyc_i`,1) cycles after the accepting edge, with the accepted byte already stable on `pio_data_o`.
- R4: `pio_req_o` falls on the first edge at which two conditions hold: `rtr_ni` has been seen low through the two-flop synchronizer, and the request has been high for at least max(`pulse_cyc_i`,1) cycles. For a peripheral that pulls `rtr_ni` low half a cycle after the request has been high for D+1 cycles, the high time is max(`pulse_cyc_i`,1, D+3) cycles.
- R5: After `pio_req_o` falls, `pio_data_o` stays unchanged and `in_ready_o` stays low for at least max(`hold_cyc_i`,1) cycles.
- R6: `pio_data_o` changes only at an accepting edge, and it shows the byte that was accepted.
- R7: After 15 acknowledged bytes, no byte is accepted and no request is raised until `eob_i` has been seen low and then high again.
- R8: If `eob_i` goes low before 15 bytes have been acknowledged, the sender finishes the byte in flight and accepts nothing more. When `eob_i` is high again, it sends a full new block of 15 bytes.
- R9: No request rises while the peripheral holds `eob_i` low.
- R10: If `rtr_ni` is not seen low within max(`tmo_cyc_i`,1) cycles of request high, the request drops after exactly that many cycles and `tmo_err_o` rises. `tmo_err_o` then stays high until reset. The timed-out byte does not count toward the block.
- R11: A programmed value of zero for setup, pulse or hold behaves exactly like one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| setup_cyc_i | input | CW | Setup cycles from byte accept to request rise |
| pulse_cyc_i | input | CW | Minimum request high cycles |
| hold_cyc_i | input | CW | Hold cycles after request fall |
| tmo_cyc_i | input | CW | Cycles allowed for the peripheral to answer |
| in_data_i | input | DW | Upstream byte |
| in_valid_i | input | 1 | Upstream byte valid |
| in_ready_o | output | 1 | Sender can take a byte |
| pio_data_o | output | DW | Parallel data bus |
| pio_req_o | output | 1 | Request strobe to the peripheral |
| rtr_ni | input | 1 | Peripheral ready-to-receive, low means byte taken |
| eob_i | input | 1 | Peripheral block window, high means open |
| tmo_err_o | output | 1 | Sticky timeout error |

## Verification
The hardest state to reach is an early block end. The window must close while a byte is still in flight, so that the sender has to drop a partial block count. The bench's peripheral model closes the window during the request phase of the fifth byte, keeps it closed long enough for the synchronizer to see it, and then expects a full 15-byte block after it reopens. Most of the run is a near-exhaustive sweep over setup, pulse, hold and peripheral answer delay, including zero settings. In each configuration the bench checks strobe and hold widths against values it works out arithmetically, and it moves the window fall a configuration-dependent number of cycles after the block so that the wait for the fall is exercised. A final pass gives no answer to one request to force the timeout.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_REQ   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WFALL = 3'd4,
    ST_WRISE = 3'd5
  } pdma_state_e;
endpackage

// File: rtl/pdma_sync.sv
module pdma_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pdma_cnt.sv
module pdma_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i && q_o != MAX) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
  import pdma_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 8,
  parameter int unsigned BLK_LEN = 15,
  parameter int unsigned BW      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] setup_cyc_i,
  input  logic [CW-1:0] pulse_cyc_i,
  input  logic [CW-1:0] hold_cyc_i,
  input  logic [CW-1:0] tmo_cyc_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  input  logic          eob_s_i,
  input  logic          ack_s_i,
  input  logic [CW-1:0] tmr_q_i,
  input  logic [BW-1:0] blk_q_i,
  output logic          in_ready_o,
  output logic [DW-1:0] pio_data_o,
  output logic          pio_req_o,
  output logic          tmo_err_o,
  output logic          tmr_clr_o,
  output logic          blk_inc_o,
  output logic          blk_clr_o
);
  localparam logic [BW-1:0] BLK_FULL = BW'(BLK_LEN);

  pdma_state_e state_q, state_d;
  logic [CW-1:0] setup_lim, pulse_lim, hold_lim, tmo_lim;
  logic ld_data, tmo_set;

  // limit = max(cfg,1) - 1
  assign setup_lim = (setup_cyc_i == '0) ? '0 : setup_cyc_i - 1'b1;
  assign pulse_lim = (pulse_cyc_i == '0) ? '0 : pulse_cyc_i - 1'b1;
  assign hold_lim  = (hold_cyc_i  == '0) ? '0 : hold_cyc_i  - 1'b1;
  assign tmo_lim   = (tmo_cyc_i   == '0) ? '0 : tmo_cyc_i   - 1'b1;

  always_comb begin
    state_d   = state_q;
    ld_data   = 1'b0;
    blk_inc_o = 1'b0;
    blk_clr_o = 1'b0;
    tmo_set   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!eob_s_i) state_d = ST_WRISE;
        else if (in_valid_i) begin
          state_d = ST_SETUP;
          ld_data = 1'b1;
        end
      end
      ST_SETUP: if (tmr_q_i >= setup_lim) state_d = ST_REQ;
      ST_REQ: begin
        if (ack_s_i) begin
          if (tmr_q_i >= pulse_lim) begin
            state_d   = ST_HOLD;
            blk_inc_o = 1'b1;
          end
        end else if (tmr_q_i >= tmo_lim) begin
          state_d = ST_HOLD;
          tmo_set = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_q_i >= hold_lim) state_d = (blk_q_i == BLK_FULL) ? ST_WFALL : ST_IDLE;
      end
      ST_WFALL: if (!eob_s_i) state_d = ST_WRISE;
      ST_WRISE: begin
        if (eob_s_i) begin
          state_d   = ST_IDLE;
          blk_clr_o = 1'b1;
        end
      end
      default: state_d = ST_WRISE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WRISE;
      pio_data_o <= '0;
      tmo_err_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_data) pio_data_o <= in_data_i;
      if (tmo_set) tmo_err_o <= 1'b1;
    end
  end

  assign tmr_clr_o  = (state_d != state_q);
  assign in_ready_o = (state_q == ST_IDLE) && eob_s_i;
  assign pio_req_o  = (state_q == ST_REQ);
endmodule

// File: rtl/pdma_tx.sv
module pdma_tx #(
  parameter int unsigned DW          = 8,
  parameter int unsigned CW          = 8,
  parameter int unsigned BLK_LEN     = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] setup_cyc_i,
  input  logic [CW-1:0] pulse_cyc_i,
  input  logic [CW-1:0] hold_cyc_i,
  input  logic [CW-1:0] tmo_cyc_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic [DW-1:0] pio_data_o,
  output logic          pio_req_o,
  input  logic          rtr_ni,
  input  logic          eob_i,
  output logic          tmo_err_o
);
  localparam int unsigned BW = $clog2(BLK_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] tmr_q;
  logic [BW-1:0] blk_q;
  logic          tmr_clr, blk_inc, blk_clr;

  // bit 1: window line, bit 0: ready-to-receive (idle high)
  pdma_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({eob_i, rtr_ni}),
    .q_o   (sync_q)
  );

  pdma_cnt #(.W(CW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .inc_i (1'b1),
    .q_o   (tmr_q)
  );

  pdma_cnt #(.W(BW)) u_blk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (blk_clr),
    .inc_i (blk_inc),
    .q_o   (blk_q)
  );

  pdma_fsm #(.DW(DW), .CW(CW), .BLK_LEN(BLK_LEN), .BW(BW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .setup_cyc_i(setup_cyc_i),
    .pulse_cyc_i(pulse_cyc_i),
    .hold_cyc_i (hold_cyc_i),
    .tmo_cyc_i  (tmo_cyc_i),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .eob_s_i    (sync_q[1]),
    .ack_s_i    (!sync_q[0]),
    .tmr_q_i    (tmr_q),
    .blk_q_i    (blk_q),
    .in_ready_o (in_ready_o),
    .pio_data_o (pio_data_o),
    .pio_req_o  (pio_req_o),
    .tmo_err_o  (tmo_err_o),
    .tmr_clr_o  (tmr_clr),
    .blk_inc_o  (blk_inc),
    .blk_clr_o  (blk_clr)
  );
endmodule

// File: rtl/pdma_tx_chk.sv
module pdma_tx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [DW-1:0] pio_data_o,
  input logic          pio_req_o,
  input logic          rtr_ni,
  input logic          tmo_err_o
);
  assert_ready_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !pio_req_o);

  assert_accept_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !pio_req_o);

  assert_setup_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pio_req_o) |-> $stable(pio_data_o));

  assert_bus_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pio_req_o && $past(pio_req_o)) |-> $stable(pio_data_o));

  assert_hold_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pio_req_o) |-> ($stable(pio_data_o) && !in_ready_o));

  assert_ack_seen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pio_req_o) && !$rose(tmo_err_o)) |-> !$past(rtr_ni, 2));

  assert_tmo_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |=> tmo_err_o);

  assert_tmo_on_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_err_o) |-> ($past(pio_req_o) && !pio_req_o));
endmodule

bind pdma_tx pdma_tx_chk #(.DW(DW)) u_chk (.*);

// File: tb/pdma_tx_tb_top.sv
module pdma_tx_tb_top;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int BLK = 15;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] setup_cyc_i = 8'd1, pulse_cyc_i = 8'd1, hold_cyc_i = 8'd1, tmo_cyc_i = 8'd12;
  logic [DW-1:0] in_data_i;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [DW-1:0] pio_data_o;
  logic pio_req_o;
  logic rtr_ni = 1'b1;
  logic eob_i = 1'b1;
  logic tmo_err_o;

  always #5 clk_i = ~clk_i;

  pdma_tx #(.DW(DW), .CW(CW), .BLK_LEN(BLK)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  int sent_idx = 0, byte_total = 0, blk_bytes = 0, tout_seen = 0;
  int cfg_d = 0, cfg_e = 0, cfg_l = 4;
  bit respond_en = 1, early_mode = 0;
  int eob_phase = 0, eob_cnt = 0, low_cnt = 0;
  bit acc_pend = 0, in_setup = 0, req_prev = 0, started = 0;
  int setup_cnt = 0, hi_cnt = 0, hold_cnt = 1000;
  logic [DW-1:0] cur = '0, bus_prev = '0;

  function automatic logic [DW-1:0] src(input int i);
    return DW'((i * 73 + 11) & 255);
  endfunction

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  assign in_data_i = src(sent_idx);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // peripheral model and monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        rtr_ni = 1'b1; eob_i = 1'b1; eob_phase = 0; blk_bytes = 0;
        acc_pend = 0; in_setup = 0; req_prev = 0; started = 0; hold_cnt = 1000;
        bus_prev = pio_data_o;
      end else begin
        // byte accepted at last edge
        if (acc_pend) begin
          acc_pend = 0;
          cur = src(sent_idx);
          sent_idx++;
          in_setup = 1; setup_cnt = 0;
          chk(pio_data_o == cur, "R2 accepted byte on bus", int'(pio_data_o), int'(cur));
          chk(hold_cnt >= eff(hold_cyc_i) + 1, "R5 hold before next accept", hold_cnt, eff(hold_cyc_i) + 1);
          started = 1;
        end else if (started) begin
          chk(pio_data_o == bus_prev, "R6 bus changed without accept", int'(pio_data_o), int'(bus_prev));
        end
        // request handling
        if (pio_req_o) begin
          if (!req_prev) begin
            chk(in_setup && setup_cnt == eff(setup_cyc_i), "R3 setup cycles", setup_cnt, eff(setup_cyc_i));
            chk(pio_data_o == cur, "R6 bus at request", int'(pio_data_o), int'(cur));
            chk(eob_phase == 0, "R9 request while window closed", eob_phase, 0);
            chk(blk_bytes < BLK, "R7 request beyond block", blk_bytes, BLK - 1);
            in_setup = 0; hi_cnt = 0;
          end
          hi_cnt++;
          if (respond_en && hi_cnt > cfg_d) rtr_ni = 1'b0;
          if (early_mode && eob_phase == 0 && blk_bytes == 4) begin
            eob_i = 1'b0; eob_phase = 2; low_cnt = 0; early_mode = 0;
          end
        end else begin
          if (in_setup) setup_cnt++;
          if (req_prev) begin
            if (!rtr_ni) begin
              chk(hi_cnt == imax(eff(pulse_cyc_i), cfg_d + 3), "R4 request width", hi_cnt,
                  imax(eff(pulse_cyc_i), cfg_d + 3));
              blk_bytes++; byte_total++;
            end else begin
              chk(hi_cnt == eff(tmo_cyc_i), "R10 timeout width", hi_cnt, eff(tmo_cyc_i));
              chk(tmo_err_o == 1'b1, "R10 timeout flag", int'(tmo_err_o), 1);
              tout_seen++;
            end
            rtr_ni = 1'b1; hold_cnt = 1;
            if (blk_bytes == BLK && eob_phase == 0) begin eob_phase = 1; eob_cnt = 0; end
          end else hold_cnt++;
        end
        // window line
        if (eob_phase == 2) begin
          low_cnt++;
          if (low_cnt >= cfg_l) begin eob_i = 1'b1; eob_phase = 0; blk_bytes = 0; end
        end else if (eob_phase == 1) begin
          eob_cnt++;
          if (eob_cnt > cfg_e) begin eob_i = 1'b0; eob_phase = 2; low_cnt = 0; end
        end
        if (in_valid_i && in_ready_o) acc_pend = 1;
        req_prev = pio_req_o;
        bus_prev = pio_data_o;
      end
    end
  end

  task automatic wait_block(input int target, input string rq);
    int n = 0;
    while (!(byte_total >= target && eob_phase == 0) && n < 3000) begin
      @(posedge clk_i); #1; n++;
    end
    chk(byte_total == target, rq, byte_total, target);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(!pio_req_o && !in_ready_o && !tmo_err_o, "R1 outputs in reset",
        int'({pio_req_o, in_ready_o, tmo_err_o}), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i); chk(!in_ready_o, "R1 ready after release", int'(in_ready_o), 0);
    @(negedge clk_i);
    @(negedge clk_i); chk(!in_ready_o, "R1 ready at third negedge", int'(in_ready_o), 0);
    @(negedge clk_i); chk(in_ready_o, "R1 ready after sync", int'(in_ready_o), 1);
    @(posedge clk_i); #1;

    // sweep with R11 zero settings
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 6; p++)
        for (int h = 0; h < 4; h++)
          for (int d = 0; d < 5; d += 2) begin
            setup_cyc_i = CW'(s); pulse_cyc_i = CW'(p); hold_cyc_i = CW'(h); tmo_cyc_i = 8'd12;
            cfg_d = d; cfg_e = ((s + p) % 3) * 4; cfg_l = 3 + h;
            in_valid_i = 1'b1;
            wait_block(byte_total + BLK, "R7 R11 block of 15");
          end

    // R8 early window close
    setup_cyc_i = 8'd1; pulse_cyc_i = 8'd1; hold_cyc_i = 8'd1; cfg_d = 0; cfg_l = 10; cfg_e = 2;
    early_mode = 1;
    wait_block(byte_total + 5, "R8 early block length");
    cfg_l = 4;
    wait_block(byte_total + BLK, "R8 full block after early end");

    // R10 timeout
    chk(!tmo_err_o, "R10 no error before timeout", int'(tmo_err_o), 0);
    tmo_cyc_i = 8'd5; respond_en = 0;
    while (tout_seen == 0) begin @(posedge clk_i); #1; end
    respond_en = 1;
    wait_block(byte_total + BLK, "R10 timed-out byte not counted");
    chk(tmo_err_o, "R10 error sticky", int'(tmo_err_o), 1);
    chk(tout_seen == 1, "R10 single timeout", tout_seen, 1);

    // R1 reset clears error
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!tmo_err_o && !pio_req_o && !in_ready_o, "R1 reset clears outputs",
        int'({tmo_err_o, pio_req_o, in_ready_o}), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(in_ready_o && !tmo_err_o, "R1 idle after second reset", int'({in_ready_o, tmo_err_o}), 2);
    finish_run();
  end
endmodule